// File: doc/BRIEF.md
# DMA Request Router with Event Gating

This block sits between a set of request sources and the request inputs of several DMA streams. The sources are the peripheral request lines plus a small bank of internal request generators. Each output channel picks one source with a 7-bit selector. In bypass mode the picked request goes straight to the stream. In gated mode it is held back until a rising edge appears on a chosen external event line. The edge then lets a programmed number of requests through, and after that the channel closes again.

Each request generator watches one external event line, which it picks itself. When that line shows a rising edge, the generator raises its request and keeps it up until it has collected a programmed number of acknowledges. Each stream returns its acknowledge to the source it currently selects, and to no other source. A mapping-table control input picks between two mappings. The flexible mapping applies the per-channel selectors. The fixed mapping wires channel c to source c+1 and ignores the selectors and the gating controls.

Channel states: CH_BYPASS (the channel is not gated and its request is forwarded), CH_WAIT (the channel is gated and closed), CH_PASS (the channel is gated and open). Transitions: BYPASS to WAIT when gating turns on with no edge present. BYPASS or WAIT to PASS on a gating edge, which loads the count. PASS to WAIT on the acknowledge that uses up the count. Any state to BYPASS when gating is off. Generator states: GEN_IDLE, GEN_ACTIVE. IDLE to ACTIVE on a trigger edge while the generator is enabled. ACTIVE to IDLE on the last counted acknowledge, or when the generator is disabled.

Top module: `dmareq_router`

## Requirements
- R1: Under the flexible mapping, a selector value of 0 gives the channel no request, and no acknowledge from that stream reaches any source.
- R2: Under the flexible mapping, selector values 1 to 123 pick peripheral line value-1, and values 124 to 127 pick generator value-124. In bypass mode `dma_req` follows the picked source in the same cycle.
- R3: When `tbl_flex` is 0, channel c carries `periph_req[c]` directly, and the selectors and gating controls have no effect.
- R4: In gated mode (`tbl_flex`=1 and `ch_sync_en` bit set) the channel forwards nothing until a rising edge appears on the event line chosen by its 3-bit `ch_sync_id` field.
- R5: After that edge the channel forwards the picked request from the next cycle. It counts `dma_ack` pulses and closes after count+1 of them, where count is the channel's 5-bit `ch_sync_cnt` field.
- R6: A gating edge that arrives while the channel is open raises `ch_ovr` for that cycle and does not change the remaining count.
- R7: An enabled generator that sees a rising edge on its chosen event line raises its request from the next cycle. It holds the request until it has received num+1 acknowledges through its source slot, and drops it in the cycle after the last one.
- R8: `periph_ack[p]` is high in exactly the cycles in which some stream with effective selector p+1 drives `dma_ack`.
- R9: After reset all channels are closed or in bypass, all generators are idle, and every output is low while inputs are low.
- R10: An edge is a 0 in the previous cycle followed by a 1. A line that stays high produces no further gating or trigger events.
- R11: Turning gating off drops any open window. When gating turns back on, the channel stays closed until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_req | input | NUM_PERIPH (123) | Peripheral request lines, selector values 1..123 |
| periph_ack | output | NUM_PERIPH (123) | Acknowledges routed back to peripherals |
| ext_line | input | NUM_EXT (8) | External event lines used for gating and triggers |
| tbl_flex | input | 1 | 1 = flexible mapping, 0 = fixed mapping |
| ch_sel | input | NUM_CH*SEL_W (28) | Per-channel 7-bit source selectors |
| ch_sync_en | input | NUM_CH (4) | Per-channel gated-mode enable |
| ch_sync_id | input | NUM_CH*EXT_W (12) | Per-channel gating event line index |
| ch_sync_cnt | input | NUM_CH*CNT_W (20) | Per-channel request count minus one per window |
| gen_en | input | NUM_GEN (4) | Generator enables |
| gen_trig_id | input | NUM_GEN*EXT_W (12) | Generator trigger line index |
| gen_num | input | NUM_GEN*CNT_W (20) | Generator acknowledge count minus one |
| dma_ack | input | NUM_CH (4) | Acknowledge from each DMA stream |
| dma_req | output | NUM_CH (4) | Request to each DMA stream |
| ch_ovr | output | NUM_CH (4) | One-cycle pulse on a gating edge while the window is open |

## Verification
The hardest case to reach from the ports is a gating edge that lands inside an open window. This needs a window that stays open for long enough, and an edge sequence that the design sees as two separate rises. The stimulus sets a large count and stops acknowledging the channel, so the window cannot close. It then drives the event line low and high again. A generator request only becomes visible through a channel that selects its slot, so the generator tests route one through a bypass channel and count the acknowledges up to the point where the request drops. A long random phase then mixes selectors, edges and acknowledges against the cycle model.

// File: rtl/dmareq_router_pkg.sv
package dmareq_router_pkg;

    typedef enum logic [1:0] {
        CH_BYPASS = 2'd0,
        CH_WAIT   = 2'd1,
        CH_PASS   = 2'd2
    } ch_state_e;

    typedef enum logic {
        GEN_IDLE   = 1'b0,
        GEN_ACTIVE = 1'b1
    } gen_state_e;

endpackage

// File: rtl/dmareq_edge_detect.sv
module dmareq_edge_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);

    logic [W-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/dmareq_gen.sv
module dmareq_gen
    import dmareq_router_pkg::*;
#(
    parameter int NUM_EXT = 8,
    parameter int EXT_W   = 3,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [EXT_W-1:0]   trig_id,
    input  logic [CNT_W-1:0]   num,
    input  logic [NUM_EXT-1:0] ext_rise,
    input  logic               ack,
    output logic               req
);

    gen_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             trig;

    assign trig = ext_rise[trig_id];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            GEN_IDLE: begin
                if (en && trig) begin
                    state_d = GEN_ACTIVE;
                    left_d  = num;
                end
            end
            GEN_ACTIVE: begin
                if (!en) begin
                    state_d = GEN_IDLE;
                end else if (ack) begin
                    if (left_q == '0) state_d = GEN_IDLE;
                    else              left_d  = left_q - 1'b1;
                end
            end
            default: state_d = GEN_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            GEN_IDLE:   req = 1'b0;
            GEN_ACTIVE: req = 1'b1;
            default:    req = 1'b0;
        endcase
    end

endmodule

// File: rtl/dmareq_chan.sv
module dmareq_chan
    import dmareq_router_pkg::*;
#(
    parameter int NUM_SRC = 127,
    parameter int SEL_W   = 7,
    parameter int NUM_EXT = 8,
    parameter int EXT_W   = 3,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [SEL_W-1:0]   sel,
    input  logic               sync_on,
    input  logic [EXT_W-1:0]   sync_id,
    input  logic [CNT_W-1:0]   sync_cnt,
    input  logic [NUM_EXT-1:0] ext_rise,
    input  logic               dma_ack,
    output logic               dma_req,
    output logic               ovr
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             sel_req;
    logic             sync_rise;
    logic             fwd;

    // selector value 0 and values above NUM_SRC pick nothing
    always_comb begin
        sel_req = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) sel_req = src[i-1];
        end
    end

    assign sync_rise = ext_rise[sync_id];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_BYPASS;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            CH_BYPASS: begin
                if (sync_on) begin
                    if (sync_rise) begin
                        state_d = CH_PASS;
                        left_d  = sync_cnt;
                    end else begin
                        state_d = CH_WAIT;
                    end
                end
            end
            CH_WAIT: begin
                if (!sync_on) begin
                    state_d = CH_BYPASS;
                end else if (sync_rise) begin
                    state_d = CH_PASS;
                    left_d  = sync_cnt;
                end
            end
            CH_PASS: begin
                if (!sync_on) begin
                    state_d = CH_BYPASS;
                end else if (dma_ack) begin
                    if (left_q == '0) state_d = CH_WAIT;
                    else              left_d  = left_q - 1'b1;
                end
            end
            default: state_d = CH_BYPASS;
        endcase
    end

    always_comb begin
        fwd = 1'b0;
        ovr = 1'b0;
        unique case (state_q)
            CH_BYPASS: fwd = !sync_on;
            CH_WAIT:   fwd = !sync_on;
            CH_PASS: begin
                fwd = 1'b1;
                ovr = sync_on && sync_rise;
            end
            default: fwd = 1'b0;
        endcase
    end

    assign dma_req = sel_req & fwd;

endmodule

// File: rtl/dmareq_router.sv
module dmareq_router
    import dmareq_router_pkg::*;
#(
    parameter int NUM_PERIPH = 123,
    parameter int NUM_GEN    = 4,
    parameter int NUM_CH     = 4,
    parameter int NUM_EXT    = 8,
    parameter int SEL_W      = 7,
    parameter int CNT_W      = 5,
    parameter int EXT_W      = $clog2(NUM_EXT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PERIPH-1:0]   periph_req,
    output logic [NUM_PERIPH-1:0]   periph_ack,
    input  logic [NUM_EXT-1:0]      ext_line,
    input  logic                    tbl_flex,
    input  logic [NUM_CH*SEL_W-1:0] ch_sel,
    input  logic [NUM_CH-1:0]       ch_sync_en,
    input  logic [NUM_CH*EXT_W-1:0] ch_sync_id,
    input  logic [NUM_CH*CNT_W-1:0] ch_sync_cnt,
    input  logic [NUM_GEN-1:0]      gen_en,
    input  logic [NUM_GEN*EXT_W-1:0] gen_trig_id,
    input  logic [NUM_GEN*CNT_W-1:0] gen_num,
    input  logic [NUM_CH-1:0]       dma_ack,
    output logic [NUM_CH-1:0]       dma_req,
    output logic [NUM_CH-1:0]       ch_ovr
);

    localparam int NUM_SRC = NUM_PERIPH + NUM_GEN;

    logic [NUM_EXT-1:0]      ext_rise;
    logic [NUM_GEN-1:0]      gen_req;
    logic [NUM_GEN-1:0]      gen_ack;
    logic [NUM_SRC-1:0]      src_all;
    logic [NUM_SRC-1:0]      src_ack;
    logic [NUM_CH*SEL_W-1:0] eff_sel_flat;

    dmareq_edge_detect #(.W(NUM_EXT)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ext_line),
        .rise  (ext_rise)
    );

    assign src_all = {gen_req, periph_req};

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        dmareq_gen #(
            .NUM_EXT (NUM_EXT),
            .EXT_W   (EXT_W),
            .CNT_W   (CNT_W)
        ) u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (gen_en[g]),
            .trig_id  (gen_trig_id[g*EXT_W +: EXT_W]),
            .num      (gen_num[g*CNT_W +: CNT_W]),
            .ext_rise (ext_rise),
            .ack      (gen_ack[g]),
            .req      (gen_req[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // fixed mapping: channel c takes source c+1 without gating
        assign eff_sel_flat[c*SEL_W +: SEL_W] =
            tbl_flex ? ch_sel[c*SEL_W +: SEL_W] : SEL_W'(c + 1);

        dmareq_chan #(
            .NUM_SRC (NUM_SRC),
            .SEL_W   (SEL_W),
            .NUM_EXT (NUM_EXT),
            .EXT_W   (EXT_W),
            .CNT_W   (CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src_all),
            .sel      (eff_sel_flat[c*SEL_W +: SEL_W]),
            .sync_on  (tbl_flex & ch_sync_en[c]),
            .sync_id  (ch_sync_id[c*EXT_W +: EXT_W]),
            .sync_cnt (ch_sync_cnt[c*CNT_W +: CNT_W]),
            .ext_rise (ext_rise),
            .dma_ack  (dma_ack[c]),
            .dma_req  (dma_req[c]),
            .ovr      (ch_ovr[c])
        );
    end

    // acknowledge goes back only to the source a stream currently selects
    always_comb begin
        src_ack = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (dma_ack[c] && (eff_sel_flat[c*SEL_W +: SEL_W] == SEL_W'(s + 1)))
                    src_ack[s] = 1'b1;
            end
        end
    end

    assign periph_ack = src_ack[NUM_PERIPH-1:0];
    assign gen_ack    = src_ack[NUM_SRC-1:NUM_PERIPH];

endmodule

// File: rtl/dmareq_router_chk.sv
module dmareq_router_chk #(
    parameter int NUM_PERIPH = 123,
    parameter int NUM_GEN    = 4,
    parameter int NUM_CH     = 4,
    parameter int SEL_W      = 7
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            tbl_flex,
    input logic [NUM_CH*SEL_W-1:0]         ch_sel,
    input logic [NUM_CH-1:0]               ch_sync_en,
    input logic [NUM_PERIPH-1:0]           periph_req,
    input logic [NUM_PERIPH-1:0]           periph_ack,
    input logic [NUM_CH-1:0]               dma_ack,
    input logic [NUM_CH-1:0]               dma_req,
    input logic [NUM_CH-1:0]               ch_ovr,
    input logic [NUM_PERIPH+NUM_GEN-1:0]   src_all,
    input logic [NUM_CH*SEL_W-1:0]         eff_sel_flat
);

    localparam int NUM_SRC = NUM_PERIPH + NUM_GEN;

    logic [NUM_CH-1:0] picked;

    always_comb begin
        picked = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int i = 1; i <= NUM_SRC; i++) begin
                if (eff_sel_flat[c*SEL_W +: SEL_W] == SEL_W'(i)) picked[c] = src_all[i-1];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk

        assert_sel_zero_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (tbl_flex && ch_sel[c*SEL_W +: SEL_W] == '0) |-> !dma_req[c]);

        assert_req_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
            dma_req[c] |-> picked[c]);

        if (c < NUM_PERIPH) begin : g_fix
            assert_fixed_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !tbl_flex |-> (dma_req[c] == periph_req[c]));
        end

        assert_ovr_only_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ch_ovr[c] |-> (tbl_flex && ch_sync_en[c]));

        assert_reenable_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ((tbl_flex && ch_sync_en[c]) && !$past(tbl_flex && ch_sync_en[c])) |-> !dma_req[c]);
    end

    assert_ack_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(periph_ack) <= $countones(dma_ack));

endmodule

bind dmareq_router dmareq_router_chk #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_GEN    (NUM_GEN),
    .NUM_CH     (NUM_CH),
    .SEL_W      (SEL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tbl_flex     (tbl_flex),
    .ch_sel       (ch_sel),
    .ch_sync_en   (ch_sync_en),
    .periph_req   (periph_req),
    .periph_ack   (periph_ack),
    .dma_ack      (dma_ack),
    .dma_req      (dma_req),
    .ch_ovr       (ch_ovr),
    .src_all      (src_all),
    .eff_sel_flat (eff_sel_flat)
);

// File: tb/dmareq_router_tb_top.sv
`timescale 1ns/1ps
module dmareq_router_tb_top;

    localparam int NP = 123;
    localparam int NG = 4;
    localparam int NC = 4;
    localparam int NE = 8;
    localparam int SW = 7;
    localparam int CW = 5;
    localparam int EW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     periph_req = '0;
    logic [NP-1:0]     periph_ack;
    logic [NE-1:0]     ext_line = '0;
    logic              tbl_flex = 1'b0;
    logic [NC*SW-1:0]  ch_sel = '0;
    logic [NC-1:0]     ch_sync_en = '0;
    logic [NC*EW-1:0]  ch_sync_id = '0;
    logic [NC*CW-1:0]  ch_sync_cnt = '0;
    logic [NG-1:0]     gen_en = '0;
    logic [NG*EW-1:0]  gen_trig_id = '0;
    logic [NG*CW-1:0]  gen_num = '0;
    logic [NC-1:0]     dma_ack = '0;
    logic [NC-1:0]     dma_req;
    logic [NC-1:0]     ch_ovr;

    logic [NC-1:0]     auto_ack = '0;

    // reference model state
    int  m_st[NC];
    int  m_left[NC];
    int  g_act[NG];
    int  g_left[NG];
    bit  ext_prev[NE];

    // values seen at the last compare point
    logic [NC-1:0] smp_req, smp_ovr, smp_dack;
    logic [NP-1:0] smp_pack;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dmareq_router dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .periph_req  (periph_req),
        .periph_ack  (periph_ack),
        .ext_line    (ext_line),
        .tbl_flex    (tbl_flex),
        .ch_sel      (ch_sel),
        .ch_sync_en  (ch_sync_en),
        .ch_sync_id  (ch_sync_id),
        .ch_sync_cnt (ch_sync_cnt),
        .gen_en      (gen_en),
        .gen_trig_id (gen_trig_id),
        .gen_num     (gen_num),
        .dma_ack     (dma_ack),
        .dma_req     (dma_req),
        .ch_ovr      (ch_ovr)
    );

    function automatic bit src_val(int i);
        if (i >= 1 && i <= NP)           return periph_req[i-1];
        if (i > NP && i <= NP + NG)      return g_act[i-NP-1] != 0;
        return 1'b0;
    endfunction

    function automatic int eff_sel(int c);
        if (tbl_flex) return int'(ch_sel[c*SW +: SW]);
        return c + 1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin m_st[c] = 0; m_left[c] = 0; end
        for (int g = 0; g < NG; g++) begin g_act[g] = 0; g_left[g] = 0; end
        for (int e = 0; e < NE; e++) ext_prev[e] = 1'b0;
    endtask

    // one clock: drive acks, compare 1 ns before the edge, advance the model
    task automatic step();
        logic [NC-1:0] e_req, e_ovr;
        logic [NP-1:0] e_pack;
        bit            g_ack[NG];
        bit            rise[NE];
        string         tag;
        @(negedge clk);
        #1;
        dma_ack = auto_ack & dma_req;
        #3;
        for (int e = 0; e < NE; e++) rise[e] = ext_line[e] && !ext_prev[e];
        e_pack = '0;
        for (int g = 0; g < NG; g++) g_ack[g] = 1'b0;
        for (int c = 0; c < NC; c++) begin
            int  es  = eff_sel(c);
            bit  s   = src_val(es);
            bit  son = tbl_flex && ch_sync_en[c];
            int  id  = int'(ch_sync_id[c*EW +: EW]);
            e_req[c] = son ? (m_st[c] == 1 && s) : s;
            e_ovr[c] = son && m_st[c] == 1 && rise[id];
            if (dma_ack[c]) begin
                if (es >= 1 && es <= NP)               e_pack[es-1] = 1'b1;
                else if (es > NP && es <= NP + NG)     g_ack[es-NP-1] = 1'b1;
            end
        end
        smp_req  = dma_req;
        smp_ovr  = ch_ovr;
        smp_pack = periph_ack;
        smp_dack = dma_ack;
        tag = !rst_n ? "R9 reset" : (!tbl_flex ? "R3 fixed map" : "R2/R4/R5 select or gating");
        n_vec++;
        if (dma_req !== e_req || ch_ovr !== e_ovr || periph_ack !== e_pack) begin
            n_bad++;
            if (dma_req !== e_req)
                $display("FAIL %s dma_req act=%b exp=%b t=%0t", tag, dma_req, e_req, $time);
            if (ch_ovr !== e_ovr)
                $display("FAIL R6 ch_ovr act=%b exp=%b t=%0t", ch_ovr, e_ovr, $time);
            if (periph_ack !== e_pack)
                $display("FAIL R8 periph_ack act=%h exp=%h t=%0t", periph_ack, e_pack, $time);
        end
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int c = 0; c < NC; c++) begin
                bit son = tbl_flex && ch_sync_en[c];
                int id  = int'(ch_sync_id[c*EW +: EW]);
                if (!son) m_st[c] = 0;
                else if (m_st[c] == 0) begin
                    if (rise[id]) begin m_st[c] = 1; m_left[c] = int'(ch_sync_cnt[c*CW +: CW]); end
                end else if (dma_ack[c]) begin
                    if (m_left[c] == 0) m_st[c] = 0;
                    else m_left[c]--;
                end
            end
            for (int g = 0; g < NG; g++) begin
                int id = int'(gen_trig_id[g*EW +: EW]);
                if (!gen_en[g]) g_act[g] = 0;
                else if (g_act[g] == 0) begin
                    if (rise[id]) begin g_act[g] = 1; g_left[g] = int'(gen_num[g*CW +: CW]); end
                end else if (g_ack[g]) begin
                    if (g_left[g] == 0) g_act[g] = 0;
                    else g_left[g]--;
                end
            end
            for (int e = 0; e < NE; e++) ext_prev[e] = ext_line[e];
        end
        @(posedge clk);
        #1;
    endtask

    task automatic set_ch(int c, int sel, bit sen, int id, int cnt);
        ch_sel[c*SW +: SW]      = SW'(sel);
        ch_sync_en[c]           = sen;
        ch_sync_id[c*EW +: EW]  = EW'(id);
        ch_sync_cnt[c*CW +: CW] = CW'(cnt);
    endtask

    initial begin
        int acks;
        model_reset();
        // R9: reset state
        for (int i = 0; i < 3; i++) step();
        chk(smp_req == '0, "R9 dma_req in reset", int'(smp_req), 0);
        chk(smp_ovr == '0, "R9 ch_ovr in reset", int'(smp_ovr), 0);
        rst_n = 1'b1;
        step();
        chk(smp_pack == '0, "R9 periph_ack after reset", int'(smp_pack != '0), 0);

        // R3: fixed mapping ignores selectors and gating
        tbl_flex = 1'b0;
        set_ch(0, 0, 1'b1, 1, 0);
        set_ch(1, 77, 1'b1, 2, 0);
        periph_req = '0;
        periph_req[3:0] = 4'b1010;
        auto_ack = '1;
        step();
        chk(smp_req == 4'b1010, "R3 fixed map pattern A", int'(smp_req), 10);
        periph_req[3:0] = 4'b0101;
        step();
        chk(smp_req == 4'b0101, "R3 fixed map pattern B", int'(smp_req), 5);
        for (int i = 0; i < 6; i++) begin periph_req = {$urandom, $urandom, $urandom, $urandom}; step(); end

        // R1 / R2 / R8: flexible bypass
        tbl_flex = 1'b1;
        set_ch(0, 5, 1'b0, 0, 0);
        set_ch(1, 0, 1'b0, 0, 0);
        set_ch(2, 123, 1'b0, 0, 0);
        set_ch(3, 1, 1'b0, 0, 0);
        periph_req = '1;
        auto_ack = 4'b0011;
        step();
        chk(smp_req[1] == 1'b0, "R1 select 0 quiet", int'(smp_req[1]), 0);
        chk(smp_req[0] == 1'b1, "R2 select 5 passes", int'(smp_req[0]), 1);
        chk(smp_pack == (NP'(1) << 4), "R8 ack to source 5 only", int'(smp_pack[4]), 1);
        periph_req[4] = 1'b0;
        step();
        chk(smp_req[0] == 1'b0, "R2 select 5 follows low", int'(smp_req[0]), 0);
        chk(smp_req[2] == 1'b1, "R2 select 123 passes", int'(smp_req[2]), 1);
        for (int i = 0; i < 6; i++) begin periph_req = {$urandom, $urandom, $urandom, $urandom}; auto_ack = 4'($urandom); step(); end

        // R4 / R5 / R10: gated channel 0 on line 2, count 2
        periph_req = '0;
        periph_req[9] = 1'b1;
        set_ch(0, 10, 1'b1, 2, 2);
        auto_ack = 4'b0001;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(smp_req[0] == 1'b0, "R4 closed before edge", int'(smp_req[0]), 0);
        end
        ext_line[2] = 1'b1;
        acks = 0;
        for (int i = 0; i < 12; i++) begin step(); if (smp_dack[0]) acks++; end
        chk(acks == 3, "R5 count+1 requests per edge", acks, 3);
        chk(smp_req[0] == 1'b0, "R10 held line no retrigger", int'(smp_req[0]), 0);

        // R6: edge while open
        set_ch(0, 10, 1'b1, 2, 20);
        auto_ack = '0;
        ext_line[2] = 1'b0; step();
        ext_line[2] = 1'b1; step();
        ext_line[2] = 1'b0; step();
        chk(smp_req[0] == 1'b1, "R5 window open", int'(smp_req[0]), 1);
        ext_line[2] = 1'b1; step();
        chk(smp_ovr[0] == 1'b1, "R6 overrun pulse", int'(smp_ovr[0]), 1);
        step();
        chk(smp_ovr[0] == 1'b0, "R6 overrun one cycle", int'(smp_ovr[0]), 0);

        // R11: gating off then on again
        ch_sync_en[0] = 1'b0; step();
        chk(smp_req[0] == 1'b1, "R11 bypass while gating off", int'(smp_req[0]), 1);
        ch_sync_en[0] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(smp_req[0] == 1'b0, "R11 closed after re-enable", int'(smp_req[0]), 0);
        end

        // R7: generator 0 on line 5, num 3, seen through channel 1 (select 124)
        ext_line = '0;
        gen_en[0] = 1'b1;
        gen_trig_id[0 +: EW] = EW'(5);
        gen_num[0 +: CW] = CW'(3);
        set_ch(1, 124, 1'b0, 0, 0);
        auto_ack = 4'b0010;
        step();
        chk(smp_req[1] == 1'b0, "R7 generator idle", int'(smp_req[1]), 0);
        ext_line[5] = 1'b1; step();
        ext_line[5] = 1'b0;
        acks = 0;
        for (int i = 0; i < 10; i++) begin step(); if (smp_dack[1]) acks++; end
        chk(acks == 4, "R7 num+1 acknowledges", acks, 4);
        chk(smp_req[1] == 1'b0, "R7 request dropped", int'(smp_req[1]), 0);

        // mixed random phase against the model
        for (int i = 0; i < 600; i++) begin
            if (i % 40 == 0) begin
                tbl_flex = ($urandom_range(0, 3) != 0);
                for (int c = 0; c < NC; c++)
                    set_ch(c, (c == 0) ? NP + 1 + $urandom_range(0, NG - 1) : $urandom_range(0, 127),
                           1'($urandom), $urandom_range(0, NE - 1), $urandom_range(0, 4));
                for (int g = 0; g < NG; g++) begin
                    gen_en[g] = 1'($urandom);
                    gen_trig_id[g*EW +: EW] = EW'($urandom_range(0, NE - 1));
                    gen_num[g*CW +: CW] = CW'($urandom_range(0, 3));
                end
            end
            periph_req = {$urandom, $urandom, $urandom, $urandom};
            ext_line   = NE'($urandom & $urandom & $urandom);
            auto_ack   = NC'($urandom);
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule